// File: doc/BRIEF.md
# Floating-Point Reciprocal Estimate Unit

This block produces a low-precision approximation of 1/x for one IEEE 754 operand. A parameter picks binary16, binary32 or binary64. The approximation carries 8 fraction bits of precision. Its value is fixed exactly by a 9-bit fixed-point estimate formula. It is not a rounded true reciprocal. Software or a Newton-Raphson refinement pipeline can start from this seed and refine it further.

The unit covers every IEEE input class: NaNs, infinities, zeros, subnormals and normal numbers.
- It can squash subnormal inputs to zero before use.
- It can flush results that would be too small to zero.
- Inputs so small that the reciprocal would overflow return either infinity or the largest finite value, chosen by the rounding mode.
- When the reciprocal falls in the subnormal range, the estimate bits are realigned to form a subnormal result.

The result and five exception flags are registered. They appear one clock after the operand is presented, and a new operand can be accepted on every cycle.

Top module: `recip_est`

## Requirements
- R1: Output timing and reset.
  - The result and flags present on the inputs before a rising clock edge appear on the outputs after that edge.
  - While rst_n is low, the result and all flags are zero.
- R2: NaN inputs (exponent all ones, fraction nonzero).
  - A signaling NaN (fraction MSB 0) raises invalid and is returned with its fraction MSB set.
  - A quiet NaN is returned unchanged with no flag.
  - With dnan_i set, every NaN returns the positive default quiet NaN instead: exponent all ones, fraction MSB 1, other bits 0, which is 0x7E00 for binary16. The invalid rule above still applies.
- R3: An infinite input returns zero with the input's sign and raises no flag.
- R4: A zero input returns infinity with the input's sign and raises only divzero.
- R5: Tiny nonzero inputs: a subnormal whose two leading fraction bits are both 0 (binary16 magnitude below 0x100).
  - overflow and inexact are raised.
  - The result is signed infinity if rmode_i rounds toward infinity for that sign, otherwise the signed largest finite value (0x7BFF magnitude for binary16).
  - rmode_i encoding: 00 = nearest-even (infinity), 01 = toward +inf (infinity only if positive), 10 = toward -inf (infinity only if negative), 11 = toward zero (never infinity).
- R6: When ftz_i is set and the biased exponent is at least 2^EW-3 (29 for binary16), underflow is raised and a zero with the input's sign is returned.
- R7: Normal inputs with biased exponent e.
  - The core input is m = {1, top 8 fraction bits}.
  - The estimate is est = ((2^19 / (2m+1)) + 1) >> 1, which lies in 256..511.
  - The result exponent is (2^EW-3) - e.
  - The result fraction is est[7:0] followed by zeros.
- R8: Subnormal inputs are normalised before the estimate.
  - If the fraction MSB is 1, the fraction is shifted left by 1 and the exponent taken as 0.
  - Otherwise it is shifted left by 2 and the exponent taken as -1.
- R9: A subnormal result is built when the result exponent would be 0 or -1.
  - For 0, the fraction is {1, est[7:0], zeros}.
  - For -1, it is {0, 1, est[7:0], zeros}.
  - In both cases the exponent field is 0.
- R10: With squash_i set, a subnormal input is treated as a zero of the same sign: it returns signed infinity and raises divzero.
- R11: Sign and flags on the estimate path.
  - Every non-NaN result carries the input's sign.
  - At most one of invalid, divzero, overflow and underflow is set.
  - The estimate path (R7 to R9) raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | W | Operand (W = 1+EW+FW) |
| rmode_i | input | 2 | Rounding mode (00 nearest, 01 up, 10 down, 11 zero) |
| ftz_i | input | 1 | Flush-to-zero enable for tiny results |
| dnan_i | input | 1 | Default-NaN enable |
| squash_i | input | 1 | Squash subnormal inputs to zero |
| res_o | output | W | Registered reciprocal estimate |
| invalid_o | output | 1 | Invalid operation flag |
| divzero_o | output | 1 | Divide-by-zero flag |
| overflow_o | output | 1 | Overflow flag |
| underflow_o | output | 1 | Underflow flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
On every cycle, the bound checker confirms several class-level rules:
- the result's sign follows the operand's sign;
- zeros produce infinity with divzero;
- infinities produce zeros with no flags;
- tiny operands raise overflow together with inexact;
- the four exclusive flags never overlap.

Only the bench's sweeps can show the exact estimate values, the exponent arithmetic, the realignment into subnormal results, the choice between infinity and the largest finite value for each rounding mode, and the NaN quieting and default-NaN substitution.

// File: rtl/recip_pkg.sv
package recip_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_UP      = 2'b01,
    RM_DOWN    = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  typedef struct packed {
    logic invalid;
    logic divzero;
    logic overflow;
    logic underflow;
    logic inexact;
  } flags_t;

  function automatic int exp_bits(input int fmt);
    case (fmt)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int frac_bits(input int fmt);
    case (fmt)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/recip_norm.sv
module recip_norm #(
  parameter int EW = 5,
  parameter int FW = 10
) (
  input  logic [EW-1:0]        exp_i,
  input  logic [FW-1:0]        frac_i,
  output logic signed [EW+1:0] e_o,
  output logic [8:0]           mant_o
);

  logic [FW-1:0] f_al;
  logic          unused_lo;

  always_comb begin
    e_o  = {2'b00, exp_i};
    f_al = frac_i;
    if (exp_i == '0) begin
      if (!frac_i[FW-1]) begin
        e_o  = '1;
        f_al = frac_i << 2;
      end else begin
        f_al = frac_i << 1;
      end
    end
  end

  assign mant_o    = {1'b1, f_al[FW-1:FW-8]};
  assign unused_lo = ^f_al[FW-9:0];

endmodule

// File: rtl/recip_core.sv
module recip_core (
  input  logic [8:0] mant_i,
  output logic [8:0] est_o
);

  logic [19:0] quo;
  logic [19:0] rnd;
  logic        unused_bits;

  always_comb begin
    quo = 20'h80000 / {10'd0, mant_i, 1'b1};
    rnd = quo + 20'd1;
  end

  assign est_o       = rnd[9:1];
  assign unused_bits = ^{rnd[19:10], rnd[0]};

endmodule

// File: rtl/recip_pack.sv
module recip_pack #(
  parameter int EW = 5,
  parameter int FW = 10
) (
  input  logic signed [EW+1:0] e_i,
  input  logic [8:0]           est_i,
  output logic [EW-1:0]        exp_o,
  output logic [FW-1:0]        frac_o
);

  localparam int OFFSET = (1 << EW) - 3;
  localparam logic signed [EW+1:0] OFF_S = OFFSET[EW+1:0];

  logic signed [EW+1:0] r_exp;
  logic [FW:0]          tpl;
  logic                 unused_top;

  always_comb begin
    r_exp = OFF_S - e_i;
    tpl   = {1'b1, est_i[7:0], {(FW-8){1'b0}}};
    if (r_exp == '0) begin
      exp_o  = '0;
      frac_o = tpl[FW:1];
    end else if (r_exp == '1) begin
      exp_o  = '0;
      frac_o = {1'b0, tpl[FW:2]};
    end else begin
      exp_o  = r_exp[EW-1:0];
      frac_o = tpl[FW-1:0];
    end
  end

  assign unused_top = est_i[8];

endmodule

// File: rtl/recip_est.sv
module recip_est
  import recip_pkg::*;
#(
  parameter int FMT = 0,
  localparam int EW = exp_bits(FMT),
  localparam int FW = frac_bits(FMT),
  localparam int W  = 1 + EW + FW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_i,
  input  logic [1:0]   rmode_i,
  input  logic         ftz_i,
  input  logic         dnan_i,
  input  logic         squash_i,
  output logic [W-1:0] res_o,
  output logic         invalid_o,
  output logic         divzero_o,
  output logic         overflow_o,
  output logic         underflow_o,
  output logic         inexact_o
);

  localparam int OFFSET = (1 << EW) - 3;
  localparam logic [EW-1:0] FTZ_LIM = OFFSET[EW-1:0];

  logic          sgn;
  logic [EW-1:0] ex;
  logic [FW-1:0] fr, fr_eff;
  logic          ex_max, is_nan, is_snan, is_inf, is_zero, is_tiny, is_ftz;
  logic          go_inf;

  logic signed [EW+1:0] n_exp;
  logic [8:0]           n_mant, est;
  logic [EW-1:0]        p_exp;
  logic [FW-1:0]        p_frac;

  logic [W-1:0] res_d, res_q;
  flags_t       flg_d, flg_q;
  rmode_e       rm;

  assign sgn    = op_i[W-1];
  assign ex     = op_i[W-2:FW];
  assign fr     = op_i[FW-1:0];
  assign fr_eff = (squash_i && ex == '0) ? '0 : fr;
  assign rm     = rmode_e'(rmode_i);

  assign ex_max  = &ex;
  assign is_nan  = ex_max && (fr != '0);
  assign is_snan = is_nan && !fr[FW-1];
  assign is_inf  = ex_max && (fr == '0);
  assign is_zero = (ex == '0) && (fr_eff == '0);
  assign is_tiny = (ex == '0) && (fr_eff[FW-1:FW-2] == 2'b00);
  assign is_ftz  = ftz_i && (ex >= FTZ_LIM);

  always_comb begin
    case (rm)
      RM_NEAREST: go_inf = 1'b1;
      RM_UP:      go_inf = !sgn;
      RM_DOWN:    go_inf = sgn;
      default:    go_inf = 1'b0;
    endcase
  end

  recip_norm #(.EW(EW), .FW(FW)) u_norm (
    .exp_i  (ex),
    .frac_i (fr_eff),
    .e_o    (n_exp),
    .mant_o (n_mant)
  );

  recip_core u_core (
    .mant_i (n_mant),
    .est_o  (est)
  );

  recip_pack #(.EW(EW), .FW(FW)) u_pack (
    .e_i    (n_exp),
    .est_i  (est),
    .exp_o  (p_exp),
    .frac_o (p_frac)
  );

  always_comb begin
    flg_d = '0;
    res_d = {sgn, p_exp, p_frac};
    if (is_nan) begin
      flg_d.invalid = is_snan;
      if (dnan_i) res_d = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
      else        res_d = {sgn, ex, 1'b1, fr[FW-2:0]};
    end else if (is_inf) begin
      res_d = {sgn, {(W-1){1'b0}}};
    end else if (is_zero) begin
      flg_d.divzero = 1'b1;
      res_d = {sgn, {EW{1'b1}}, {FW{1'b0}}};
    end else if (is_tiny) begin
      flg_d.overflow = 1'b1;
      flg_d.inexact  = 1'b1;
      if (go_inf) res_d = {sgn, {EW{1'b1}}, {FW{1'b0}}};
      else        res_d = {sgn, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
    end else if (is_ftz) begin
      flg_d.underflow = 1'b1;
      res_d = {sgn, {(W-1){1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign res_o       = res_q;
  assign invalid_o   = flg_q.invalid;
  assign divzero_o   = flg_q.divzero;
  assign overflow_o  = flg_q.overflow;
  assign underflow_o = flg_q.underflow;
  assign inexact_o   = flg_q.inexact;

endmodule

// File: rtl/recip_est_chk.sv
module recip_est_chk #(
  parameter int EW = 5,
  parameter int FW = 10,
  parameter int W  = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_i,
  input logic         squash_i,
  input logic [W-1:0] res_o,
  input logic         invalid_o,
  input logic         divzero_o,
  input logic         overflow_o,
  input logic         underflow_o,
  input logic         inexact_o
);

  logic [EW-1:0] c_ex;
  logic [FW-1:0] c_fr;
  logic          c_nan, c_inf, c_zero, c_tiny;

  assign c_ex   = op_i[W-2:FW];
  assign c_fr   = op_i[FW-1:0];
  assign c_nan  = (&c_ex) && (c_fr != '0);
  assign c_inf  = (&c_ex) && (c_fr == '0);
  assign c_zero = (c_ex == '0) && (c_fr == '0);
  assign c_tiny = (c_ex == '0) && (c_fr != '0) && !squash_i &&
                  (c_fr[FW-1:FW-2] == 2'b00);

  // R11: sign follows the operand for every non-NaN input
  assert_sign_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !c_nan |=> res_o[W-1] == $past(op_i[W-1]));

  // R11: exclusive flags never overlap
  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({invalid_o, divzero_o, overflow_o, underflow_o}));

  // R3: infinity gives zero magnitude and no flags
  assert_inf_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_inf |=> (res_o[W-2:0] == '0) &&
              !(invalid_o || divzero_o || overflow_o || underflow_o || inexact_o));

  // R4: zero gives infinity with divzero
  assert_zero_dbz_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_zero |=> divzero_o && (res_o[W-2:0] == {{EW{1'b1}}, {FW{1'b0}}}));

  // R5: tiny operands overflow and are inexact
  assert_no_overflow_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    c_tiny |=> overflow_o && inexact_o);

endmodule

bind recip_est recip_est_chk #(.EW(EW), .FW(FW), .W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .squash_i    (squash_i),
  .res_o       (res_o),
  .invalid_o   (invalid_o),
  .divzero_o   (divzero_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o),
  .inexact_o   (inexact_o)
);

// File: tb/sim_recip_est.sv
module sim_recip_est;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] op;
  logic [1:0]  rm;
  logic        ftz, dn, sq;
  logic [15:0] res;
  logic        f_inv, f_dbz, f_ovf, f_unf, f_inx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  recip_est #(.FMT(0)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op),
    .rmode_i     (rm),
    .ftz_i       (ftz),
    .dnan_i      (dn),
    .squash_i    (sq),
    .res_o       (res),
    .invalid_o   (f_inv),
    .divzero_o   (f_dbz),
    .overflow_o  (f_ovf),
    .underflow_o (f_unf),
    .inexact_o   (f_inx)
  );

  logic [15:0] exp_res;
  logic [4:0]  exp_flg;
  string       exp_tag;

  task automatic model(input logic [15:0] a, input logic [1:0] m,
                       input logic fz, input logic dnn, input logic sqz);
    logic       s;
    logic [4:0] e;
    logic [9:0] f;
    int         mant, be, est;
    logic       to_inf;
    s = a[15]; e = a[14:10]; f = a[9:0];
    exp_flg = 5'b0;
    if (e == 5'd31 && f != 0) begin
      exp_tag = "R2";
      exp_flg[4] = !f[9];
      exp_res = dnn ? 16'h7E00 : (a | 16'h0200);
    end else if (e == 5'd31) begin
      exp_tag = "R3";
      exp_res = {s, 15'h0000};
    end else if (e == 0 && (f == 0 || sqz)) begin
      exp_tag = (f != 0) ? "R10" : "R4";
      exp_flg[3] = 1'b1;
      exp_res = {s, 15'h7C00};
    end else if (e == 0 && f < 10'd256) begin
      exp_tag = "R5";
      exp_flg[2] = 1'b1;
      exp_flg[0] = 1'b1;
      to_inf = (m == 2'b00) || (m == 2'b01 && !s) || (m == 2'b10 && s);
      exp_res = to_inf ? {s, 15'h7C00} : {s, 15'h7BFF};
    end else if (fz && e >= 5'd29) begin
      exp_tag = "R6";
      exp_flg[1] = 1'b1;
      exp_res = {s, 15'h0000};
    end else begin
      if (e != 0) begin
        mant = 256 + int'(f[9:2]);
        be = 29 - int'(e);
        exp_tag = "R7";
      end else if (f[9]) begin
        mant = int'(f[9:1]);
        be = 29;
        exp_tag = "R8";
      end else begin
        mant = int'(f[8:0]);
        be = 30;
        exp_tag = "R8";
      end
      est = ((524288 / (2 * mant + 1)) + 1) / 2;
      if (be >= 1) begin
        exp_res = {s, be[4:0], est[7:0], 2'b00};
      end else begin
        exp_tag = "R9";
        if (be == 0) exp_res = {s, 5'd0, est[8:0], 1'b0};
        else         exp_res = {s, 5'd0, 1'b0, est[8:0]};
      end
    end
  endtask

  task automatic compare(input string tag, input logic [15:0] er, input logic [4:0] ef);
    n_cmp++;
    if (res !== er || {f_inv, f_dbz, f_ovf, f_unf, f_inx} !== ef) begin
      n_bad++;
      $display("FAIL %s op=%h rm=%b ftz=%b dn=%b sq=%b: got res=%h flags=%b, want res=%h flags=%b",
               tag, op, rm, ftz, dn, sq, res, {f_inv, f_dbz, f_ovf, f_unf, f_inx}, er, ef);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [1:0] m,
                       input logic fz, input logic dnn, input logic sqz);
    op = a; rm = m; ftz = fz; dn = dnn; sq = sqz;
    model(a, m, fz, dnn, sqz);
    @(negedge clk);
    compare(exp_tag, exp_res, exp_flg);
  endtask

  initial begin
    rst_n = 1'b0;
    op = 16'h3C00; rm = 2'b00; ftz = 1'b0; dn = 1'b0; sq = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state is all zero
    compare("R1", 16'h0000, 5'b0);
    rst_n = 1'b1;
    // R1: one-cycle latency, 1.0 -> 0x3BFC ( est 511 )
    apply(16'h3C00, 2'b00, 1'b0, 1'b0, 1'b0);
    // R2: signaling NaN quieted with invalid
    apply(16'hFC01, 2'b00, 1'b0, 1'b0, 1'b0);
    // R5: each rounding mode for a negative tiny input
    for (int k = 0; k < 4; k++) apply(16'h8001, k[1:0], 1'b0, 1'b0, 1'b0);
    // R6: flush at exponent 29 only when enabled
    apply(16'h7400, 2'b00, 1'b1, 1'b0, 1'b0);
    apply(16'h7400, 2'b00, 1'b0, 1'b0, 1'b0);
    // R10: squashed subnormal
    apply(16'h8200, 2'b00, 1'b0, 1'b0, 1'b1);
    // R7 R8 R9 R11: exhaustive sweeps
    for (int i = 0; i < 65536; i++)
      apply(i[15:0], i[1:0], 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 65536; i++)
      apply(i[15:0], i[2:1], 1'b1, 1'b1, 1'b1);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule